// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Burst Controller

This block is the host side of a three-wire serial EEPROM link (chip select, serial clock, data toward the memory, data back from the memory). A caller gives it a start address, a word count, a direction and an address width of 6 or 8 bits. The block then transfers that range of 16-bit words one word at a time. Each word gets its own command, and chip select drops between words. Words read back leave on a one-cycle strobe. Words to be written are pulled in through a ready/valid handshake.

A write burst sits between a write-enable command and a write-disable command. The length of both commands follows the address width. After each written word the block polls the memory's busy line until it reports completion. A poll that runs too long ends the burst with an error, and the disable command is still sent. Each half of the serial clock lasts `HALF_DIV` system clocks, so a single parameter sets the minimum high, low and select times of the memory.

Top module: `uwire_eeprom_ctrl`

## Requirements
- R1: After reset, and whenever `busy` is low, `ee_cs`, `ee_sk`, `ee_do`, `done`, `err`, `rd_valid` and `wr_ready` are all 0.
- R2: Every half period of `ee_sk` lasts exactly `HALF_DIV` cycles. Each bit is a low half followed by a high half. `ee_do` takes the bit value at the start of the low half and holds it through the high half.
- R3: A request is accepted in the cycle in which `start` is high while the block is idle. Every command opens with one full `ee_sk` period with `ee_cs` high and `ee_do` 0. All fields are then sent MSB first.
- R4: A read word sends 1,1,0, then the address, then 17 more `ee_sk` periods with `ee_do` 0. `ee_di` is sampled in the last cycle of each low half. The first sample is discarded and the next 16 form `rd_data`, MSB first. `rd_valid` is high for one cycle, in the first cycle after the 17th period.
- R5: After each command, `ee_cs` is low for one full `ee_sk` period (low half, then high half) with `ee_do` 0.
- R6: A write burst starts with the enable command: 1,0,0,1,1 followed by zeros. It is 9 bits long with `wide_addr`=0 and 11 bits with `wide_addr`=1. The R5 period follows it.
- R7: Before each written word, `wr_ready` is high with `ee_cs` and `ee_sk` low until `wr_valid` is high. `wr_data` is taken in that cycle. The word then goes out as 1,0,1, the address, and the 16 data bits.
- R8: After the data bits, `ee_cs` and `ee_sk` stay low for one half period. Then `ee_cs` rises and `ee_sk` periods continue until `ee_di` is 1 in the last cycle of a high half. The R5 period follows.
- R9: After the last written word, the disable command is sent: 1,0,0 followed by zeros, with the same length as R6. The R5 period follows it.
- R10: The address is 6 bits when `wide_addr`=0 and 8 bits when it is 1. It rises by one per word and wraps within that width.
- R11: If `POLL_LIMIT` poll periods all see `ee_di`=0, the remaining words are skipped. The disable command is still sent, and `err` is high together with `done`.
- R12: `done` is a one-cycle pulse in the cycle after the final R5 period. `busy` is high from the cycle after acceptance through the `done` cycle.
- R13: `start` is ignored while `busy` is high.
- R14: A request with `word_count`=0 raises `done` in the cycle after acceptance and produces no serial activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe |
| op_write | input | 1 | 1 = write burst, 0 = read burst |
| wide_addr | input | 1 | 1 = 8-bit address, 0 = 6-bit address |
| start_addr | input | 8 | First word address |
| word_count | input | CNT_W | Number of words |
| busy | output | 1 | Request in progress |
| done | output | 1 | End-of-request pulse |
| err | output | 1 | Poll timeout, valid with done |
| rd_valid | output | 1 | Read word strobe |
| rd_data | output | 16 | Read word |
| wr_ready | output | 1 | Controller wants the next write word |
| wr_valid | input | 1 | Write word offered |
| wr_data | input | 16 | Write word |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Memory serial clock |
| ee_do | output | 1 | Serial data to the memory |
| ee_di | input | 1 | Serial data from the memory |

## Verification
The serial pins change on the first edge after acceptance. Every later event follows from a count of `HALF_DIV`-cycle halves: `rd_valid` comes in the first cycle of the deselect period that follows the 17th read period, `wr_ready` sits in the cycle or cycles before each write command, and `done` comes one cycle after the last deselect period. The bench turns each request into a list of expected values with one entry per cycle, counted from the accepting edge. It compares every output against that list at the falling edge of each cycle. It also drives `ee_di` and `wr_valid` from the same entry, so that each sample lands on the clock edge the requirements name.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

    localparam int WORD_W   = 16;
    localparam int RD_SLOTS = 17;

    typedef enum logic [3:0] {
        ST_IDLE, ST_SEL, ST_HDR, ST_RDATA, ST_WDATA,
        ST_GAP, ST_POLL, ST_RST, ST_WREQ, ST_FIN
    } state_e;

    typedef enum logic [1:0] {CMD_EN, CMD_RD, CMD_WR, CMD_DIS} cmd_e;

    typedef struct packed {
        logic       is_write;
        logic       wide;
        logic [7:0] addr;
    } req_t;

    // Header bit count: start + two opcode bits + address field
    function automatic logic [4:0] hdr_len(logic wide);
        return wide ? 5'd11 : 5'd9;
    endfunction

    // Header left-aligned in a 16-bit shift word
    function automatic logic [15:0] hdr_word(cmd_e c, logic wide, logic [7:0] a);
        logic [1:0] op;
        logic [7:0] fld;
        case (c)
            CMD_RD:  op = 2'b10;
            CMD_WR:  op = 2'b01;
            default: op = 2'b00;
        endcase
        if (c == CMD_EN)       fld = 8'hC0;
        else if (c == CMD_DIS) fld = 8'h00;
        else                   fld = wide ? a : {a[5:0], 2'b00};
        return {1'b1, op, fld, 5'b0};
    endfunction

    function automatic logic [7:0] next_addr(logic wide, logic [7:0] a);
        return wide ? a + 8'd1 : {2'b00, a[5:0] + 6'd1};
    endfunction

endpackage

// File: rtl/uwire_phase_timer.sv
module uwire_phase_timer #(
    parameter int HALF_DIV = 160
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic phase_end,
    output logic half
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt  <= '0;
            half <= 1'b0;
        end else if (cnt == LAST) begin
            cnt  <= '0;
            half <= ~half;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign phase_end = (cnt == LAST);

    AST_HALF_HELD: assert property (@(posedge clk) disable iff (rst)
        (!clr && cnt != LAST) |=> $stable(half)); // R2

endmodule

// File: rtl/uwire_shifter.sv
module uwire_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         sample,
    input  logic         si,
    output logic         so,
    output logic [W-1:0] rx
);
    logic [W-1:0] tx;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx <= '0;
            rx <= '0;
        end else begin
            if (load)       tx <= load_val;
            else if (shift) tx <= {tx[W-2:0], 1'b0};
            if (sample)     rx <= {rx[W-2:0], si};
        end
    end

    assign so = tx[W-1];

endmodule

// File: rtl/uwire_eeprom_ctrl.sv
module uwire_eeprom_ctrl
    import uwire_pkg::*;
#(
    parameter int HALF_DIV   = 160,
    parameter int POLL_LIMIT = 20000,
    parameter int CNT_W      = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              op_write,
    input  logic              wide_addr,
    input  logic [7:0]        start_addr,
    input  logic [CNT_W-1:0]  word_count,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              wr_ready,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_do,
    input  logic              ee_di
);
    localparam int PW = $clog2(POLL_LIMIT + 1);
    localparam logic [PW-1:0] POLL_LAST = PW'(POLL_LIMIT - 1);

    state_e             state;
    cmd_e               cmd;
    req_t               req;
    logic [CNT_W-1:0]   remaining;
    logic [WORD_W-1:0]  wdata_q;
    logic [4:0]         bit_cnt;
    logic [PW-1:0]      poll_cnt;
    logic               err_q, aborted, rdv_q;

    logic phase_end, half, slot_end, timed, clr;
    logic load_en, shift_en, sample_en, so, last_hdr;
    logic [WORD_W-1:0] load_val;

    always_comb begin
        timed = state inside {ST_SEL, ST_HDR, ST_RDATA, ST_WDATA, ST_GAP, ST_POLL, ST_RST};
        clr   = !timed || (state == ST_GAP && phase_end);
    end

    uwire_phase_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk(clk), .rst(rst), .clr(clr), .phase_end(phase_end), .half(half)
    );

    assign slot_end = phase_end && half;
    assign last_hdr = (bit_cnt == hdr_len(req.wide) - 5'd1);

    always_comb begin
        load_en   = slot_end && ((state == ST_SEL) ||
                    (state == ST_HDR && last_hdr && cmd == CMD_WR));
        load_val  = (state == ST_SEL) ? hdr_word(cmd, req.wide, req.addr) : wdata_q;
        shift_en  = slot_end && (state == ST_HDR || state == ST_WDATA);
        sample_en = (state == ST_RDATA) && phase_end && !half;
    end

    uwire_shifter #(.W(WORD_W)) u_shift (
        .clk(clk), .rst(rst), .load(load_en), .load_val(load_val),
        .shift(shift_en), .sample(sample_en), .si(ee_di), .so(so), .rx(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cmd       <= CMD_RD;
            req       <= '0;
            remaining <= '0;
            wdata_q   <= '0;
            bit_cnt   <= '0;
            poll_cnt  <= '0;
            err_q     <= 1'b0;
            aborted   <= 1'b0;
            rdv_q     <= 1'b0;
        end else begin
            rdv_q <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    err_q   <= 1'b0;
                    aborted <= 1'b0;
                    if (word_count == '0) begin
                        state <= ST_FIN;
                    end else begin
                        req.is_write <= op_write;
                        req.wide     <= wide_addr;
                        req.addr     <= wide_addr ? start_addr : {2'b00, start_addr[5:0]};
                        remaining    <= word_count;
                        cmd          <= op_write ? CMD_EN : CMD_RD;
                        state        <= ST_SEL;
                    end
                end
                ST_SEL: if (slot_end) begin
                    bit_cnt <= '0;
                    state   <= ST_HDR;
                end
                ST_HDR: if (slot_end) begin
                    if (last_hdr) begin
                        bit_cnt <= '0;
                        case (cmd)
                            CMD_RD:  state <= ST_RDATA;
                            CMD_WR:  state <= ST_WDATA;
                            default: state <= ST_RST;
                        endcase
                    end else begin
                        bit_cnt <= bit_cnt + 5'd1;
                    end
                end
                ST_RDATA: if (slot_end) begin
                    if (bit_cnt == 5'(RD_SLOTS - 1)) begin
                        rdv_q <= 1'b1;
                        state <= ST_RST;
                    end else begin
                        bit_cnt <= bit_cnt + 5'd1;
                    end
                end
                ST_WDATA: if (slot_end) begin
                    if (bit_cnt == 5'(WORD_W - 1)) begin
                        poll_cnt <= '0;
                        state    <= ST_GAP;
                    end else begin
                        bit_cnt <= bit_cnt + 5'd1;
                    end
                end
                ST_GAP: if (phase_end) state <= ST_POLL;
                ST_POLL: if (slot_end) begin
                    if (ee_di) begin
                        state <= ST_RST;
                    end else if (poll_cnt == POLL_LAST) begin
                        err_q   <= 1'b1;
                        aborted <= 1'b1;
                        state   <= ST_RST;
                    end else begin
                        poll_cnt <= poll_cnt + 1'b1;
                    end
                end
                ST_RST: if (slot_end) begin
                    case (cmd)
                        CMD_EN:  state <= ST_WREQ;
                        CMD_DIS: state <= ST_FIN;
                        CMD_RD: begin
                            remaining <= remaining - 1'b1;
                            req.addr  <= next_addr(req.wide, req.addr);
                            state     <= (remaining == CNT_W'(1)) ? ST_FIN : ST_SEL;
                        end
                        default: begin
                            remaining <= remaining - 1'b1;
                            req.addr  <= next_addr(req.wide, req.addr);
                            if (aborted || remaining == CNT_W'(1)) begin
                                cmd   <= CMD_DIS;
                                state <= ST_SEL;
                            end else begin
                                state <= ST_WREQ;
                            end
                        end
                    endcase
                end
                ST_WREQ: if (wr_valid) begin
                    wdata_q <= wr_data;
                    cmd     <= CMD_WR;
                    state   <= ST_SEL;
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_FIN);
    assign err      = (state == ST_FIN) && err_q;
    assign rd_valid = rdv_q;
    assign wr_ready = (state == ST_WREQ);
    assign ee_cs    = state inside {ST_SEL, ST_HDR, ST_RDATA, ST_WDATA, ST_POLL};
    assign ee_sk    = half && (state inside {ST_SEL, ST_HDR, ST_RDATA, ST_WDATA, ST_POLL, ST_RST});
    assign ee_do    = so && (state inside {ST_HDR, ST_WDATA});

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ee_cs && !ee_sk && !ee_do && !rd_valid && !wr_ready)); // R1
    AST_DO_HELD_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(ee_sk) |-> $stable(ee_do)); // R2
    AST_RDV_AT_DESELECT: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (!ee_cs && $past(ee_cs))); // R4
    AST_WREQ_BUS_IDLE: assert property (@(posedge clk) disable iff (rst)
        wr_ready |-> (!ee_cs && !ee_sk)); // R7
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        err |-> done); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R12
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && start) |=> busy); // R13

endmodule

// File: tb/uwire_eeprom_ctrl_tb.sv
module uwire_eeprom_ctrl_tb;

    localparam int HD = 3;
    localparam int PL = 6;
    localparam int CW = 9;
    localparam int WATCHDOG = 150000;

    typedef struct {
        bit          cs, sk, dout, di, wv;
        logic [15:0] wd;
        bit          busy, done, err, rdv, wrr;
        logic [15:0] rdata;
        string       tag;
    } exp_t;

    logic clk = 1'b0, rst = 1'b1;
    logic start = 1'b0, op_write = 1'b0, wide_addr = 1'b0;
    logic [7:0] start_addr = '0;
    logic [CW-1:0] word_count = '0;
    logic busy, done, err, rd_valid, wr_ready, ee_cs, ee_sk, ee_do;
    logic [15:0] rd_data;
    logic wr_valid = 1'b0, ee_di = 1'b0;
    logic [15:0] wr_data = '0;

    exp_t q[$];
    int rd_ptr = 0, checks = 0, errors = 0, cyc = 0;
    bit cur_wv = 1'b1, pend_rdv = 1'b0, cur_err = 1'b0;
    logic [15:0] cur_wd = '0, pend_word = '0;

    always #2.5 clk = ~clk;   // 200 MHz

    uwire_eeprom_ctrl #(.HALF_DIV(HD), .POLL_LIMIT(PL), .CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst), .start(start), .op_write(op_write),
        .wide_addr(wide_addr), .start_addr(start_addr), .word_count(word_count),
        .busy(busy), .done(done), .err(err), .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_data(wr_data),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_do(ee_do), .ee_di(ee_di)
    );

    function automatic exp_t idle_entry();
        exp_t e;
        e = '{cs:0, sk:0, dout:0, di:0, wv:0, wd:'0, busy:0, done:0, err:0,
              rdv:0, wrr:0, rdata:'0, tag:"R1"};
        return e;
    endfunction

    function automatic logic [15:0] mem_word(logic [7:0] a);
        return {a, ~a} ^ 16'h5A3C;
    endfunction

    function automatic logic [7:0] wrap(bit wide, logic [7:0] a);
        return wide ? a + 8'd1 : {2'b00, a[5:0] + 6'd1};
    endfunction

    task automatic push_cyc(bit cs, bit sk, bit dout, bit di, string tag,
                            bit wrr = 0, bit dn = 0, bit er = 0);
        exp_t e;
        e = '{cs:cs, sk:sk, dout:dout, di:di, wv:cur_wv, wd:cur_wd, busy:1, done:dn,
              err:er, rdv:pend_rdv, wrr:wrr, rdata:pend_word, tag:tag};
        pend_rdv = 1'b0;
        q.push_back(e);
    endtask

    // R2: one half period is HD cycles
    task automatic phase(bit cs, bit sk, bit dout, bit di, string tag);
        repeat (HD) push_cyc(cs, sk, dout, di, tag);
    endtask

    task automatic slot(bit cs, bit dout, bit dil, bit dih, string tag);
        phase(cs, 1'b0, dout, dil, tag);
        phase(cs, 1'b1, dout, dih, tag);
    endtask

    task automatic send_bits(logic [15:0] v, int n, string tag);
        for (int i = n - 1; i >= 0; i--) slot(1'b1, v[i], 1'b0, 1'b0, tag);
    endtask

    task automatic model_read_word(bit wide, logic [7:0] a);
        logic [15:0] w;
        w = mem_word(a);
        slot(1'b1, 1'b0, 1'b0, 1'b0, "R3");
        send_bits(16'b110, 3, "R4");
        send_bits({8'h00, a}, wide ? 8 : 6, "R10");
        for (int k = 0; k < 17; k++)
            slot(1'b1, 1'b0, (k == 0) ? 1'b0 : w[16 - k], 1'b0, "R4");
        pend_rdv = 1'b1;
        pend_word = w;
        slot(1'b0, 1'b0, 1'b0, 1'b0, "R5");
    endtask

    task automatic model_short_cmd(bit wide, bit enable);
        slot(1'b1, 1'b0, 1'b0, 1'b0, "R3");
        send_bits(16'b100, 3, enable ? "R6" : "R9");
        if (enable) send_bits(wide ? 16'h00C0 : 16'h0030, wide ? 8 : 6, "R6");
        else        send_bits(16'h0000, wide ? 8 : 6, "R9");
        slot(1'b0, 1'b0, 1'b0, 1'b0, "R5");
    endtask

    // returns 1 when the poll timed out
    task automatic model_write_word(bit wide, logic [7:0] a, int stall, int polls, output bit tout);
        logic [15:0] w;
        w = mem_word(a) ^ 16'hFFFF;
        for (int s = 0; s < stall; s++) begin
            cur_wv = 1'b0;
            push_cyc(1'b0, 1'b0, 1'b0, 1'b0, "R7", 1'b1);
        end
        cur_wv = 1'b1;
        cur_wd = w;
        push_cyc(1'b0, 1'b0, 1'b0, 1'b0, "R7", 1'b1);
        slot(1'b1, 1'b0, 1'b0, 1'b0, "R3");
        send_bits(16'b101, 3, "R7");
        send_bits({8'h00, a}, wide ? 8 : 6, "R10");
        send_bits(w, 16, "R7");
        phase(1'b0, 1'b0, 1'b0, 1'b0, "R8");
        tout = (polls > PL);
        if (tout) begin
            for (int k = 0; k < PL; k++) slot(1'b1, 1'b0, 1'b0, 1'b0, "R11");
        end else begin
            for (int k = 0; k < polls; k++) slot(1'b1, 1'b0, 1'b0, (k == polls - 1), "R8");
        end
        slot(1'b0, 1'b0, 1'b0, 1'b0, "R5");
    endtask

    // Builds the expected list starting with the window before the accepting edge
    task automatic launch(bit wr, bit wide, logic [7:0] a, int cnt, int stall,
                          int poll0, int polln, int poke, string fin_tag);
        int base;
        bit tout;
        logic [7:0] ad;
        @(posedge clk); #1;
        base = q.size();
        q.push_back(idle_entry());
        ad = wide ? a : {2'b00, a[5:0]};
        tout = 1'b0;
        if (cnt == 0) begin
            // nothing on the bus (R14)
        end else if (!wr) begin
            for (int i = 0; i < cnt; i++) begin
                model_read_word(wide, ad);
                ad = wrap(wide, ad);
            end
        end else begin
            model_short_cmd(wide, 1'b1);
            for (int i = 0; i < cnt && !tout; i++) begin
                model_write_word(wide, ad, (i == 0) ? stall : 0, (i == 0) ? poll0 : polln, tout);
                ad = wrap(wide, ad);
            end
            model_short_cmd(wide, 1'b0);
        end
        push_cyc(1'b0, 1'b0, 1'b0, 1'b0, fin_tag, 1'b0, 1'b1, tout);
        if (poke > 0)
            for (int i = base + poke + 2; i < q.size(); i++) q[i].tag = "R13";
        start = 1'b1; op_write = wr; wide_addr = wide; start_addr = a; word_count = CW'(cnt);
        @(posedge clk); #1;
        start = 1'b0;
        if (poke > 0) begin
            repeat (poke) @(posedge clk);
            #1;
            start = 1'b1; op_write = ~wr; word_count = CW'(7); start_addr = 8'h11;
            @(posedge clk); #1;
            start = 1'b0;
        end
        wait (rd_ptr >= q.size());
        repeat (3) @(posedge clk);
    endtask

    always @(negedge clk) begin
        exp_t e;
        if (rst) begin
            ee_di = 1'b0;
            wr_valid = 1'b0;
        end else begin
            if (rd_ptr < q.size()) begin
                e = q[rd_ptr];
                rd_ptr++;
            end else begin
                e = idle_entry();
            end
            ee_di = e.di;
            wr_valid = e.wv;
            wr_data = e.wd;
            checks++;
            if (ee_cs !== e.cs || ee_sk !== e.sk || ee_do !== e.dout || busy !== e.busy ||
                done !== e.done || err !== e.err || rd_valid !== e.rdv || wr_ready !== e.wrr ||
                (e.rdv && rd_data !== e.rdata)) begin
                errors++;
                $display("FAIL %s (R2 cycle %0d): cs,sk,do,busy,done,err,rdv,wrr=%b%b%b%b%b%b%b%b rd=%h expected %b%b%b%b%b%b%b%b rd=%h",
                         e.tag, cyc, ee_cs, ee_sk, ee_do, busy, done, err, rd_valid, wr_ready, rd_data,
                         e.cs, e.sk, e.dout, e.busy, e.done, e.err, e.rdv, e.wrr, e.rdata);
            end
            cyc++;
            if (cyc == WATCHDOG) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual cycle %0d expected completion before %0d", cyc, WATCHDOG);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        repeat (4) @(posedge clk);                          // R1 idle after reset
        launch(0, 0, 8'd5,   2, 0, 0, 0, 0, "R12");         // R4 narrow read
        launch(0, 1, 8'hFE,  3, 0, 0, 0, 0, "R12");         // R10 wide wrap
        launch(0, 0, 8'd63,  2, 0, 0, 0, 0, "R12");         // R10 narrow wrap
        launch(1, 0, 8'd10,  2, 2, 3, 1, 0, "R12");         // R6 R7 R8 R9
        launch(1, 1, 8'd200, 1, 0, 2, 2, 40, "R12");        // R13 poke while busy
        launch(1, 0, 8'd20,  3, 0, 9, 1, 0, "R11");         // R11 timeout
        launch(0, 0, 8'd3,   0, 0, 0, 0, 0, "R14");         // R14 zero count
        launch(0, 1, 8'h7F,  1, 0, 0, 0, 0, "R12");         // R4 wide read
        repeat (5) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule